// File: doc/BRIEF.md
# Display-Identification I2C Slave

This block lets an external host read and write a 256-byte display-identification RAM over a two-wire I2C bus. It watches SCL and SDA through synchronizers and finds START and STOP conditions. It compares the address byte against a programmable slave address, with a choice of 5, 6 or 7 compared bits. It acknowledges a match by pulling SDA low through an open-drain enable output.

In a write transfer, the first data byte sets the internal byte pointer. Every later byte is stored at the pointer, and the pointer then advances. A read started with a repeated START returns bytes from the current pointer, one after another, until the host answers with a NACK.

Each 128-byte half of the RAM has its own host-write protection. A protected byte is still acknowledged and still advances the pointer, but the RAM keeps its old value. A lower-only mode folds every host access into bytes 00h to 7Fh.

A local CPU port reads and writes the RAM directly, independent of bus activity.

Top module: `edid_i2c_slave`

## Requirements
- R1: While cfgEnable is 0 the block never asserts sdaOe. Bus transfers then get no ACK and leave the RAM unchanged.
- R2: With cfgLenCode = 00 the block answers (ACK, sdaOe high during the ninth SCL pulse) only when address byte bits [7:1] equal cfgSlaveAddr exactly. Bit 0 of the address byte is the R/W bit, with 1 meaning read. Any other address gets no ACK.
- R3: cfgLenCode = 10 compares only address bits [6:2], and cfgLenCode = 01 compares only bits [6:1]. The code 11 behaves as 00 and compares all seven bits.
- R4: With cfgLowWrEn = 0, host writes to bytes 00h..7Fh leave the RAM unchanged. Those bytes are still ACKed and the pointer still advances.
- R5: With cfgHighWrEn = 0, host writes to bytes 80h..FFh leave the RAM unchanged. Writes to the lower half are not affected.
- R6: With cfgLowOnly = 1, pointer bit 7 is treated as 0 for every host read and write. The pointer wraps from 7Fh to 00h.
- R7: After a matching write address, the first data byte loads the pointer. Each later byte is written at the pointer and the pointer increments, wrapping from FFh to 00h. Every byte is ACKed.
- R8: After a repeated START with a read address, the block shifts out bytes MSB first from the current pointer, incrementing after each byte. A master NACK ends the transfer with SDA released.
- R9: cpuWe = 1 writes cpuWdata to RAM byte cpuAddr on that clock edge. cpuRdata shows the byte at cpuAddr one clock after cpuAddr is applied.
- R10: After reset, and after a STOP at any point in a transfer (even inside a byte), sdaOe is 0 and the block waits for a new START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Bus clock line as seen on the pin |
| sdaIn | input | 1 | Bus data line as seen on the pin |
| sdaOe | output | 1 | Drives SDA low when 1, otherwise released |
| cfgEnable | input | 1 | Slave enable |
| cfgSlaveAddr | input | 7 | Slave address to answer |
| cfgLenCode | input | 2 | Compared address length: 10 = 5 bits, 01 = 6 bits, 00/11 = 7 bits |
| cfgLowWrEn | input | 1 | Host may write bytes 00h..7Fh |
| cfgHighWrEn | input | 1 | Host may write bytes 80h..FFh |
| cfgLowOnly | input | 1 | Fold host accesses into the lower 128 bytes |
| cpuWe | input | 1 | Local RAM write strobe |
| cpuAddr | input | 8 | Local RAM byte address |
| cpuWdata | input | 8 | Local RAM write data |
| cpuRdata | output | 8 | Local RAM read data, one clock latency |

## Verification
The hardest situations to reach are the ones where the bus and the pointer disagree with the RAM contents.

The first is a write that crosses from a protected lower half into a writable upper half. The bench starts a write at 7Fh with only the upper half enabled. The byte at 7Fh must stay unchanged, and the next byte must land at 80h.

The second is a lower-only read that wraps from 7Fh back to 00h. It is reached by a sequential read started at 7Fh.

The third is a STOP placed inside an address byte, after only three bits. The bench bit-bangs this case directly, then checks that the next clean address still gets an ACK.

// File: rtl/edid_pkg.sv
package edid_pkg;

  // Strobes from the bus controller to the RAM datapath
  typedef struct packed {
    logic rxShift;   // shift rxBit into the receive register
    logic rxBit;     // sampled SDA value
    logic ptrLoad;   // completed byte becomes the pointer
    logic ramWrite;  // completed byte is stored at the pointer
    logic txLoad;    // fetch byte at pointer into transmit register
    logic txShift;   // advance transmit register by one bit
  } dpCmd_t;

  // Address bits compared for each length code
  function automatic logic [6:0] lenMask(input logic [1:0] code);
    case (code)
      2'b10:   lenMask = 7'b1111100;
      2'b01:   lenMask = 7'b1111110;
      default: lenMask = 7'b1111111;
    endcase
  endfunction

endpackage

// File: rtl/edid_ctrl.sv
module edid_ctrl
  import edid_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic       cfgEnable,
  input  logic [6:0] cfgSlaveAddr,
  input  logic [1:0] cfgLenCode,
  input  logic       txBit,
  input  logic [6:0] rxLow,
  output dpCmd_t     cmd,
  output logic       sdaOe
);

  localparam int PIPE_W = SYNC_STAGES + 1;

  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_ACK, S_RX, S_TX, S_MACK, S_MWAIT
  } state_t;

  logic [PIPE_W-1:0] sclPipe, sdaPipe;
  logic sclQ, sclPrev, sdaQ, sdaPrev;
  logic sclRise, sclFall, startDet, stopDet;
  state_t state;
  logic [2:0] bitCnt;
  logic ackDrive, ackToTx, firstByte;
  logic [7:0] fullByte;
  logic addrMatch;

  // synchronizer chain plus one stage for edge detection
  genvar g;
  generate
    for (g = 0; g < PIPE_W; g++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sclPipe[g] <= 1'b1;
          sdaPipe[g] <= 1'b1;
        end else if (g == 0) begin
          sclPipe[g] <= sclIn;
          sdaPipe[g] <= sdaIn;
        end else begin
          sclPipe[g] <= sclPipe[(g == 0) ? 0 : g-1];
          sdaPipe[g] <= sdaPipe[(g == 0) ? 0 : g-1];
        end
      end
    end
  endgenerate

  assign sclQ     = sclPipe[PIPE_W-2];
  assign sclPrev  = sclPipe[PIPE_W-1];
  assign sdaQ     = sdaPipe[PIPE_W-2];
  assign sdaPrev  = sdaPipe[PIPE_W-1];
  assign sclRise  = sclQ & ~sclPrev;
  assign sclFall  = ~sclQ & sclPrev;
  assign startDet = sclQ & sclPrev & sdaPrev & ~sdaQ;
  assign stopDet  = sclQ & sclPrev & ~sdaPrev & sdaQ;

  assign fullByte  = {rxLow, sdaQ};
  assign addrMatch = (((fullByte[7:1] ^ cfgSlaveAddr) & lenMask(cfgLenCode)) == 7'd0);

  always_comb begin
    cmd = '0;
    cmd.rxBit = sdaQ;
    if (cfgEnable && !startDet && !stopDet) begin
      case (state)
        S_ADDR: cmd.rxShift = sclRise;
        S_RX: begin
          cmd.rxShift = sclRise;
          if (sclRise && bitCnt == 3'd7) begin
            cmd.ptrLoad  = firstByte;
            cmd.ramWrite = ~firstByte;
          end
        end
        S_ACK:   cmd.txLoad  = sclFall & ackDrive & ackToTx;
        S_TX:    cmd.txShift = sclFall & (bitCnt != 3'd7);
        S_MWAIT: cmd.txLoad  = sclFall;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      bitCnt    <= 3'd0;
      ackDrive  <= 1'b0;
      ackToTx   <= 1'b0;
      firstByte <= 1'b0;
    end else if (!cfgEnable || stopDet) begin
      state    <= S_IDLE;
      ackDrive <= 1'b0;
    end else if (startDet) begin
      state    <= S_ADDR;
      bitCnt   <= 3'd0;
      ackDrive <= 1'b0;
    end else begin
      case (state)
        S_ADDR: if (sclRise) begin
          bitCnt <= bitCnt + 3'd1;
          if (bitCnt == 3'd7) begin
            if (addrMatch) begin
              state     <= S_ACK;
              ackToTx   <= fullByte[0];
              firstByte <= 1'b1;
            end else begin
              state <= S_IDLE;
            end
          end
        end
        S_ACK: if (sclFall) begin
          if (!ackDrive) begin
            ackDrive <= 1'b1;
          end else begin
            ackDrive <= 1'b0;
            bitCnt   <= 3'd0;
            state    <= ackToTx ? S_TX : S_RX;
          end
        end
        S_RX: if (sclRise) begin
          bitCnt <= bitCnt + 3'd1;
          if (bitCnt == 3'd7) begin
            state     <= S_ACK;
            ackToTx   <= 1'b0;
            firstByte <= 1'b0;
          end
        end
        S_TX: if (sclFall) begin
          if (bitCnt == 3'd7) state <= S_MACK;
          else bitCnt <= bitCnt + 3'd1;
        end
        S_MACK: if (sclRise) state <= sdaQ ? S_IDLE : S_MWAIT;
        S_MWAIT: if (sclFall) begin
          state  <= S_TX;
          bitCnt <= 3'd0;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign sdaOe = cfgEnable & ((state == S_ACK && ackDrive) || (state == S_TX && !txBit));

  // R1
  disabled_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfgEnable |=> state == S_IDLE);

  // R10
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfgEnable && stopDet) |=> (state == S_IDLE && !sdaOe));

  // R2
  sda_change_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdaOe) |-> !sclQ);

endmodule

// File: rtl/edid_dp.sv
module edid_dp
  import edid_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  dpCmd_t            cmd,
  input  logic              cfgLowWrEn,
  input  logic              cfgHighWrEn,
  input  logic              cfgLowOnly,
  input  logic              cpuWe,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  output logic [DATA_W-1:0] cpuRdata,
  output logic [DATA_W-1:0] rxByte,
  output logic              txBit
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam int TOP   = ADDR_W - 1;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] ptr, effPtr;
  logic [DATA_W-1:0] rxReg, txReg, inByte;
  logic              wrAllowed;

  assign effPtr    = cfgLowOnly ? {1'b0, ptr[TOP-1:0]} : ptr;
  assign inByte    = {rxReg[DATA_W-2:0], cmd.rxBit};
  assign wrAllowed = effPtr[TOP] ? cfgHighWrEn : cfgLowWrEn;
  assign rxByte    = rxReg;
  assign txBit     = txReg[DATA_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr   <= '0;
      rxReg <= '0;
      txReg <= '1;
    end else begin
      if (cmd.rxShift) rxReg <= inByte;
      if (cmd.ptrLoad) ptr <= inByte[ADDR_W-1:0];
      else if (cmd.ramWrite || cmd.txLoad) ptr <= effPtr + 1'b1;
      if (cmd.txLoad) txReg <= mem[effPtr];
      else if (cmd.txShift) txReg <= {txReg[DATA_W-2:0], 1'b1};
    end
  end

  // local port has priority over a same-cycle host write
  always_ff @(posedge clk) begin
    if (cpuWe) mem[cpuAddr] <= cpuWdata;
    else if (cmd.ramWrite && wrAllowed) mem[effPtr] <= inByte;
    cpuRdata <= mem[cpuAddr];
  end

  // R4 R5
  protect_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd.ramWrite && !wrAllowed && !cpuWe) |=> mem[$past(effPtr)] == $past(mem[effPtr]));

  // R8
  tx_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd.txLoad, cmd.txShift, cmd.rxShift}));

endmodule

// File: rtl/edid_i2c_slave.sv
module edid_i2c_slave
  import edid_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sdaOe,
  input  logic              cfgEnable,
  input  logic [6:0]        cfgSlaveAddr,
  input  logic [1:0]        cfgLenCode,
  input  logic              cfgLowWrEn,
  input  logic              cfgHighWrEn,
  input  logic              cfgLowOnly,
  input  logic              cpuWe,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  output logic [DATA_W-1:0] cpuRdata
);

  dpCmd_t            cmd;
  logic [DATA_W-1:0] rxByte;
  logic              txBit;

  edid_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .sclIn(sclIn), .sdaIn(sdaIn),
    .cfgEnable(cfgEnable), .cfgSlaveAddr(cfgSlaveAddr), .cfgLenCode(cfgLenCode),
    .txBit(txBit), .rxLow(rxByte[6:0]), .cmd(cmd), .sdaOe(sdaOe)
  );

  edid_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .cmd(cmd),
    .cfgLowWrEn(cfgLowWrEn), .cfgHighWrEn(cfgHighWrEn), .cfgLowOnly(cfgLowOnly),
    .cpuWe(cpuWe), .cpuAddr(cpuAddr), .cpuWdata(cpuWdata), .cpuRdata(cpuRdata),
    .rxByte(rxByte), .txBit(txBit)
  );

endmodule

// File: tb/edid_i2c_slave_tb.sv
module edid_i2c_slave_tb;

  localparam int T = 10;

  logic clk = 0, rst_n = 0;
  logic sclM = 1, sdaM = 1;
  logic sdaOe;
  logic cfgEnable = 1;
  logic [6:0] cfgSlaveAddr = 7'h50;
  logic [1:0] cfgLenCode = 2'b00;
  logic cfgLowWrEn = 1, cfgHighWrEn = 1, cfgLowOnly = 0;
  logic cpuWe = 0;
  logic [7:0] cpuAddr = 0, cpuWdata = 0, cpuRdata;
  wire sdaLine = sdaM & ~sdaOe;

  int checks = 0, fails = 0, oeCount = 0, cycles = 0;
  logic [7:0] model [256];

  always #5 clk = ~clk;

  edid_i2c_slave u_dut (
    .clk(clk), .rst_n(rst_n), .sclIn(sclM), .sdaIn(sdaLine), .sdaOe(sdaOe),
    .cfgEnable(cfgEnable), .cfgSlaveAddr(cfgSlaveAddr), .cfgLenCode(cfgLenCode),
    .cfgLowWrEn(cfgLowWrEn), .cfgHighWrEn(cfgHighWrEn), .cfgLowOnly(cfgLowOnly),
    .cpuWe(cpuWe), .cpuAddr(cpuAddr), .cpuWdata(cpuWdata), .cpuRdata(cpuRdata)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (sdaOe) oeCount <= oeCount + 1;
  end

  // {lenCode, cfgSlaveAddr, probe address, expected ACK}
  localparam logic [16:0] VEC [8] = '{
    {2'b00, 7'h50, 7'h50, 1'b1},
    {2'b00, 7'h50, 7'h51, 1'b0},
    {2'b01, 7'h50, 7'h51, 1'b1},
    {2'b01, 7'h50, 7'h52, 1'b0},
    {2'b10, 7'h50, 7'h53, 1'b1},
    {2'b10, 7'h50, 7'h54, 1'b0},
    {2'b11, 7'h50, 7'h51, 1'b0},
    {2'b00, 7'h50, 7'h10, 1'b0}
  };

  task automatic waitT(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic i2cStart();
    sdaM = 1; waitT(T); sclM = 1; waitT(T); sdaM = 0; waitT(T); sclM = 0; waitT(T);
  endtask

  task automatic i2cStop();
    sdaM = 0; waitT(T); sclM = 1; waitT(T); sdaM = 1; waitT(T);
  endtask

  task automatic sendBit(input logic b);
    sdaM = b; waitT(T); sclM = 1; waitT(T); sclM = 0; waitT(T);
  endtask

  task automatic sendByte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) sendBit(b[i]);
    sdaM = 1; waitT(T); sclM = 1; waitT(T/2); ack = ~sdaLine; waitT(T/2);
    sclM = 0; waitT(T);
  endtask

  task automatic readByte(input logic ackIt, output logic [7:0] b);
    sdaM = 1;
    for (int i = 7; i >= 0; i--) begin
      waitT(T); sclM = 1; waitT(T/2); b[i] = sdaLine; waitT(T/2); sclM = 0;
    end
    waitT(T); sdaM = ~ackIt; waitT(T); sclM = 1; waitT(T); sclM = 0; waitT(T); sdaM = 1;
  endtask

  // returns ACK bits {addr, ptr, d0, d1, d2}
  task automatic hostWrite(input logic [7:0] p, input int n, input logic [23:0] d,
                           output logic [4:0] acks);
    logic a;
    acks = '0;
    i2cStart();
    sendByte({7'h50, 1'b0}, a); acks[4] = a;
    sendByte(p, a); acks[3] = a;
    for (int k = 0; k < n; k++) begin
      sendByte(d[23-8*k -: 8], a); acks[2-k] = a;
    end
    i2cStop();
  endtask

  task automatic hostRead(input logic [7:0] p, input int n, output logic [23:0] r);
    logic a;
    logic [7:0] b;
    r = '0;
    i2cStart();
    sendByte({7'h50, 1'b0}, a);
    sendByte(p, a);
    i2cStart();
    sendByte({7'h50, 1'b1}, a);
    for (int k = 0; k < n; k++) begin
      readByte(k != n-1, b);
      r[23-8*k -: 8] = b;
    end
    i2cStop();
  endtask

  // expected effect of host writes, from R4..R7
  task automatic modelWrite(input logic [7:0] p, input int n, input logic [23:0] d);
    logic [7:0] e;
    e = p;
    for (int k = 0; k < n; k++) begin
      if (cfgLowOnly) e[7] = 1'b0;
      if (e[7] ? cfgHighWrEn : cfgLowWrEn) model[e] = d[23-8*k -: 8];
      e = e + 8'd1;
    end
  endtask

  task automatic cpuWrite(input logic [7:0] a, input logic [7:0] d);
    cpuAddr = a; cpuWdata = d; cpuWe = 1; waitT(1); cpuWe = 0; model[a] = d;
  endtask

  task automatic cpuRead(input logic [7:0] a, output logic [7:0] d);
    cpuAddr = a; waitT(1); d = cpuRdata;
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    waitT(50000);
    checks++; fails++;
    $display("FAIL watchdog actual=%0d expected=done", cycles);
    finishRun();
  end

  initial begin
    logic [7:0] d;
    logic [4:0] acks;
    logic [23:0] r;
    logic a;

    waitT(5); rst_n = 1; waitT(5);
    chk("R10 reset sdaOe", {7'd0, sdaOe}, 8'h00);

    // R9 preload through the local port
    for (int i = 0; i < 256; i++) cpuWrite(i[7:0], i[7:0] ^ 8'hA5);
    cpuRead(8'h00, d); chk("R9 cpu 00", d, 8'hA5);
    cpuRead(8'h7F, d); chk("R9 cpu 7F", d, 8'hDA);
    cpuRead(8'hFF, d); chk("R9 cpu FF", d, 8'h5A);

    // R2 R3 address matching table
    for (int i = 0; i < 8; i++) begin
      cfgLenCode   = VEC[i][16:15];
      cfgSlaveAddr = VEC[i][14:8];
      i2cStart();
      sendByte({VEC[i][7:1], 1'b0}, a);
      i2cStop();
      chk((VEC[i][16:15] == 2'b00) ? "R2 match" : "R3 match", {7'd0, a}, {7'd0, VEC[i][0]});
    end
    cfgLenCode = 2'b00; cfgSlaveAddr = 7'h50;

    // R7 sequential write
    hostWrite(8'h10, 3, 24'h112233, acks); modelWrite(8'h10, 3, 24'h112233);
    chk("R7 acks", {3'd0, acks}, 8'h1F);
    for (int i = 0; i < 3; i++) begin
      cpuRead(8'h10 + i[7:0], d); chk("R7 data", d, model[8'h10 + i[7:0]]);
    end

    // R8 sequential read, then released
    hostRead(8'h10, 3, r);
    chk("R8 byte0", r[23:16], model[8'h10]);
    chk("R8 byte1", r[15:8], model[8'h11]);
    chk("R8 byte2", r[7:0], model[8'h12]);
    chk("R8 released", {7'd0, sdaOe}, 8'h00);

    // R7 wrap FF -> 00
    hostWrite(8'hFE, 3, 24'h010203, acks); modelWrite(8'hFE, 3, 24'h010203);
    cpuRead(8'hFE, d); chk("R7 wrap FE", d, 8'h01);
    cpuRead(8'hFF, d); chk("R7 wrap FF", d, 8'h02);
    cpuRead(8'h00, d); chk("R7 wrap 00", d, 8'h03);

    // R4 lower half protected, crossing into upper half
    cfgLowWrEn = 0;
    hostWrite(8'h7F, 2, 24'h889900, acks); modelWrite(8'h7F, 2, 24'h889900);
    chk("R4 acks", {3'd0, acks}, 8'h1E);
    cpuRead(8'h7F, d); chk("R4 7F kept", d, 8'hDA);
    cpuRead(8'h80, d); chk("R4 80 written", d, 8'h99);
    cfgLowWrEn = 1;

    // R5 upper half protected
    cfgHighWrEn = 0;
    hostWrite(8'h90, 1, 24'h550000, acks); modelWrite(8'h90, 1, 24'h550000);
    cpuRead(8'h90, d); chk("R5 90 kept", d, 8'h35);
    hostWrite(8'h30, 1, 24'h440000, acks); modelWrite(8'h30, 1, 24'h440000);
    cpuRead(8'h30, d); chk("R5 30 written", d, 8'h44);
    cfgHighWrEn = 1;

    // R6 lower-only folding
    cpuWrite(8'h85, 8'hC3); cpuWrite(8'h05, 8'h3C);
    cfgLowOnly = 1;
    hostRead(8'h85, 1, r); chk("R6 fold read", r[23:16], 8'h3C);
    hostRead(8'h7F, 2, r);
    chk("R6 wrap 7F", r[23:16], model[8'h7F]);
    chk("R6 wrap 00", r[15:8], model[8'h00]);
    hostWrite(8'h90, 1, 24'h660000, acks); modelWrite(8'h90, 1, 24'h660000);
    cpuRead(8'h90, d); chk("R6 90 untouched", d, 8'h35);
    cpuRead(8'h10, d); chk("R6 10 written", d, 8'h66);
    cfgLowOnly = 0;

    // R1 disabled slave
    cfgEnable = 0; waitT(2); oeCount = 0;
    hostWrite(8'h30, 1, 24'hEE0000, acks);
    chk("R1 no ack", {3'd0, acks}, 8'h00);
    cpuRead(8'h30, d); chk("R1 ram kept", d, 8'h44);
    chk("R1 never driven", oeCount[7:0], 8'h00);
    cfgEnable = 1; waitT(2);

    // R10 STOP inside address byte, then a clean address
    i2cStart(); sendBit(1'b1); sendBit(1'b0); sendBit(1'b1); i2cStop();
    chk("R10 stop mid-byte", {7'd0, sdaOe}, 8'h00);
    i2cStart(); sendByte({7'h50, 1'b0}, a); i2cStop();
    chk("R10 restart ack", {7'd0, a}, 8'h01);

    finishRun();
  end

endmodule